// File: doc/BRIEF.md
# SPI BCD Real-Time Clock

This block is a real-time clock that an SPI master reaches as a slave device. It keeps seconds, minutes, hours, weekday, day, month and year as packed BCD counters, with a century flag. A one-cycle `tick_1hz` pulse advances the counters. The hour register works in either a 24-hour format or a 12-hour format with a PM flag. Two sticky status flags report an oscillator stop and a low supply voltage.

Every SPI transaction opens with a command byte. The byte names a 4-bit register address and one of four access kinds: single read, single write, burst read or burst write. A burst moves to the next address after each data byte. While a burst covers the time registers, carries from the tick are deferred. The master therefore reads or writes a consistent snapshot, and the deferred carry is applied once chip select drops.

SCK, MOSI and chip select are resynchronised into `clk`. The SCK period must span several `clk` cycles.

Top module: `spi_bcd_rtc`

## Requirements
- R1: The command byte carries the register address in bits 7:4 and the access kind in bits 3:2: 2'b10 is a single write (low nibble 0x8), 2'b11 is a single read (0xC), 2'b00 is a burst write (0x0) and 2'b01 is a burst read (0x4). Bits 1:0 are ignored.
- R2: SPI runs in mode 1 with an active-high chip select. The slave samples MOSI on the falling SCK edge and updates MISO on the rising edge, MSB first. MISO is 0 while chip select is low and during the command byte.
- R3: The register map is: 0 seconds (bits 6:0), 1 minutes (6:0), 2 hours (5:0), 3 weekday (2:0), 4 day (5:0), 5 month (4:0, century flag in bit 7), 6 year (7:0), 14 control A (bit 5 = 24-hour mode) and 15 control B (bit 4 = oscillator stop, bit 6 = low voltage). Bits outside these fields read 0, so seconds bit 7 is always 0. Addresses 7 to 13 read 0x00 and ignore writes.
- R4: A single access touches only the first data byte. Later bytes in the same transaction write nothing and read 0x00.
- R5: A burst access steps the address by one after every data byte and wraps from 15 to 0.
- R6: After reset the registers hold 12 AM (hours 0x12), 00 minutes and 00 seconds, weekday 0, day 0x01, month 0x01, year 0x00, century 0, control A 0x00 and control B 0x10.
- R7: The oscillator-stop flag is set by reset. While it is set, ticks do not change the time. A write to control B can only clear flags: each flag is ANDed with its bit of the written data.
- R8: The low-voltage flag is set on every cycle that `vlow_in` is high. It stays set until a write to control B clears it.
- R9: In 24-hour mode, seconds and minutes wrap 59 to 00 and carry. Hours run 00 to 23, and 23 wraps to 00 with a carry into the day.
- R10: In 12-hour mode (control A bit 5 = 0), hours bit 5 is the PM flag and the hour runs 12, 01 ... 11. Going from 11 to 12 toggles PM, and 11 PM to 12 AM carries into the day.
- R11: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 29 for month 02 when the year is divisible by four, otherwise 28; 31 for the rest. Month 12 wraps to 01 and carries into the year. The weekday counts 0 to 6 and wraps, stepping with the day.
- R12: When the year wraps from 99 to 00, the century flag toggles.
- R13: While a burst access that started at an address from 0 to 6 is in progress, a tick is held pending and the time does not change. The pending tick is applied in the first cycle after chip select deasserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | SPI data from the master |
| spi_miso | output | 1 | SPI data to the master |
| spi_cs | input | 1 | Chip select, active high |
| tick_1hz | input | 1 | One-cycle pulse that advances the time |
| vlow_in | input | 1 | Low-voltage indication, sets the sticky flag |

## Verification
The bench builds the block with its defaults: two synchronizer stages, deferred carry enabled, a weekday that wraps after 6, and a 12-hour reset format. The 12-hour reset makes the 0x12 reset hour and the PM sequence observable. With deferral enabled, a tick injected after a burst-read command must leave the minutes byte unchanged within that burst, and must appear in a later read. The seven-value weekday lets the Saturday-to-Sunday wrap be checked at the year boundary together with the century toggle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
   localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
   localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
   localparam logic [ADDR_W-1:0] A_WDAY = 4'd3;
   localparam logic [ADDR_W-1:0] A_DAY  = 4'd4;
   localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
   localparam logic [ADDR_W-1:0] A_YEAR = 4'd6;
   localparam logic [ADDR_W-1:0] A_CTLA = 4'd14;
   localparam logic [ADDR_W-1:0] A_CTLB = 4'd15;

   typedef enum logic [1:0] {
      ACC_BWR = 2'b00,
      ACC_BRD = 2'b01,
      ACC_SWR = 2'b10,
      ACC_SRD = 2'b11
   } acc_e;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [2:0] wday;
      logic [5:0] day;
      logic       cent;
      logic [4:0] mon;
      logic [7:0] year;
   } clock_t;

   // next packed-BCD value, wrapping from last to first
   function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                           input logic [7:0] last,
                                           input logic [7:0] first);
      if (v == last)
         return first;
      else if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four, on a packed-BCD year
   function automatic logic leap_bcd(input logic [7:0] y);
      if (!y[4])
         return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else
         return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   function automatic logic [7:0] month_end(input logic [4:0] m,
                                            input logic [7:0] y);
      case (m)
         5'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_spi_port.sv
module rtc_spi_port #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       mosi_i,
   input  logic       cs_i,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       miso_o,
   output logic       cs_act,
   output logic       rx_valid,
   output logic       rx_first,
   output logic [7:0] rx_byte
);

   localparam int CHAIN_W = 3 * SYNC_STAGES;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rtc_spi_port: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic sck_s, mosi_s, cs_s;
   logic sck_d, cs_d;
   logic [2:0] bit_cnt;
   logic [6:0] sh_in;
   logic       first_q;
   logic [7:0] tx_sh;
   logic       miso_q;
   logic       sck_rise, sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-4:0], sck_i, mosi_i, cs_i};
   end

   assign {sck_s, mosi_s, cs_s} = chain_q[CHAIN_W-1 -: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_rise = cs_s &&  sck_s && !sck_d;
   assign sck_fall = cs_s && !sck_s &&  sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sh_in   <= '0;
         first_q <= 1'b1;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else if (!cs_s) begin
         bit_cnt <= '0;
         first_q <= 1'b1;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else begin
         if (sck_fall) begin
            sh_in   <= {sh_in[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) first_q <= 1'b0;
         end
         if (sck_rise) begin
            miso_q <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
         end
         if (tx_load) tx_sh <= tx_byte;
      end
   end

   assign rx_valid = sck_fall && (bit_cnt == 3'd7);
   assign rx_byte  = {sh_in, mosi_s};
   assign rx_first = first_q;
   assign cs_act   = cs_s;
   assign miso_o   = miso_q;

   // R2
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && !cs_d) |-> !miso_q)
      else $error("miso active while deselected");

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
   import rtc_pkg::*;
#(
   parameter int WDAY_LAST = 6,
   parameter bit RESET_H24 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              h24,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output clock_t            now
);

   localparam logic [2:0] WDAY_MAX = 3'(WDAY_LAST);
   localparam logic [5:0] HOUR_RST = RESET_H24 ? 6'h00 : 6'h12;

   if (WDAY_LAST < 1 || WDAY_LAST > 7) begin : g_bad_wday
      $error("rtc_timekeep: WDAY_LAST out of range");
   end

   clock_t cur, nx;
   logic [7:0] s_n, m_n, h_n, d_n, mo_n, y_n, d_last, h12_n;
   logic       c_min, c_hour, c_day, c_mon, c_year;
   logic       pm;

   always_comb begin
      s_n    = bcd_step({1'b0, cur.sec}, 8'h59, 8'h00);
      m_n    = bcd_step({1'b0, cur.min}, 8'h59, 8'h00);
      h_n    = bcd_step({2'b0, cur.hour}, 8'h23, 8'h00);
      h12_n  = bcd_step({3'b0, cur.hour[4:0]}, 8'h12, 8'h01);
      d_last = month_end(cur.mon, cur.year);
      d_n    = bcd_step({2'b0, cur.day}, 8'hFF, 8'h01);
      mo_n   = bcd_step({3'b0, cur.mon}, 8'h12, 8'h01);
      y_n    = bcd_step(cur.year, 8'h99, 8'h00);
      pm     = cur.hour[5];

      c_min  = (cur.sec == 7'h59);
      c_hour = c_min && (cur.min == 7'h59);

      nx = cur;
      nx.sec = s_n[6:0];
      if (c_min) nx.min = m_n[6:0];

      c_day = 1'b0;
      if (c_hour) begin
         if (h24) begin
            nx.hour = h_n[5:0];
            c_day   = (cur.hour == 6'h23);
         end else if (cur.hour[4:0] == 5'h11) begin
            nx.hour = {~pm, 5'h12};
            c_day   = pm;
         end else if (cur.hour[4:0] == 5'h12) begin
            nx.hour = {pm, 5'h01};
         end else begin
            nx.hour = {pm, h12_n[4:0]};
         end
      end

      c_mon = c_day && ({2'b0, cur.day} >= d_last);
      if (c_day) begin
         nx.wday = (cur.wday >= WDAY_MAX) ? 3'd0 : cur.wday + 3'd1;
         nx.day  = c_mon ? 6'h01 : d_n[5:0];
      end

      c_year = c_mon && (cur.mon == 5'h12);
      if (c_mon) nx.mon = mo_n[4:0];
      if (c_year) begin
         nx.year = y_n;
         if (cur.year == 8'h99) nx.cent = ~cur.cent;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur.sec  <= 7'h00;
         cur.min  <= 7'h00;
         cur.hour <= HOUR_RST;
         cur.wday <= 3'd0;
         cur.day  <= 6'h01;
         cur.cent <= 1'b0;
         cur.mon  <= 5'h01;
         cur.year <= 8'h00;
      end else if (wr_en) begin
         case (wr_addr)
            A_SEC:  cur.sec  <= wr_data[6:0];
            A_MIN:  cur.min  <= wr_data[6:0];
            A_HOUR: cur.hour <= wr_data[5:0];
            A_WDAY: cur.wday <= wr_data[2:0];
            A_DAY:  cur.day  <= wr_data[5:0];
            A_MON: begin
               cur.cent <= wr_data[7];
               cur.mon  <= wr_data[4:0];
            end
            A_YEAR: cur.year <= wr_data;
            default: ;
         endcase
      end else if (adv) begin
         cur <= nx;
      end
   end

   assign now = cur;

   // R13
   no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !adv)
      else $error("advance and write in one cycle");

   // R9
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cur.sec == 7'h59) |=> (cur.sec == 7'h00))
      else $error("seconds did not wrap");

endmodule

// File: rtl/spi_bcd_rtc.sv
module spi_bcd_rtc
   import rtc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit DEFER_CARRY = 1'b1,
   parameter int WDAY_LAST   = 6,
   parameter bit RESET_H24   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   input  logic spi_cs,
   input  logic tick_1hz,
   input  logic vlow_in
);

   logic       cs_act, rx_valid, rx_first;
   logic [7:0] rx_byte;
   logic       tx_load;
   logic [7:0] tx_byte;

   rtc_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_i    (spi_sck),
      .mosi_i   (spi_mosi),
      .cs_i     (spi_cs),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte),
      .miso_o   (spi_miso),
      .cs_act   (cs_act),
      .rx_valid (rx_valid),
      .rx_first (rx_first),
      .rx_byte  (rx_byte)
   );

   acc_e              cmd_acc;
   logic              cmd_rd;
   logic              cmd_ok, single_q, rdm_q, used_q, start_lo;
   logic [ADDR_W-1:0] addr_q, rd_addr;
   logic              h24_q, xstp_q, vlow_q, pend_q;
   logic              wr_commit, tk_wr, adv, hold, ctlb_wr;
   clock_t            now;

   assign cmd_acc = acc_e'(rx_byte[3:2]);
   assign cmd_rd  = (cmd_acc == ACC_SRD) || (cmd_acc == ACC_BRD);

   assign wr_commit = rx_valid && !rx_first && cmd_ok && !rdm_q &&
                      (!single_q || !used_q);
   assign tk_wr     = wr_commit && (addr_q <= A_YEAR);
   assign ctlb_wr   = wr_commit && (addr_q == A_CTLB);
   assign tx_load   = rx_valid && ((rx_first && cmd_rd) ||
                      (!rx_first && cmd_ok && rdm_q && !single_q));
   assign rd_addr   = rx_first ? rx_byte[7:4] : addr_q + 4'd1;

   always_comb begin
      case (rd_addr)
         A_SEC:   tx_byte = {1'b0, now.sec};
         A_MIN:   tx_byte = {1'b0, now.min};
         A_HOUR:  tx_byte = {2'b0, now.hour};
         A_WDAY:  tx_byte = {5'b0, now.wday};
         A_DAY:   tx_byte = {2'b0, now.day};
         A_MON:   tx_byte = {now.cent, 2'b0, now.mon};
         A_YEAR:  tx_byte = now.year;
         A_CTLA:  tx_byte = {2'b0, h24_q, 5'b0};
         A_CTLB:  tx_byte = {1'b0, vlow_q, 1'b0, xstp_q, 4'b0};
         default: tx_byte = 8'h00;
      endcase
   end

   if (DEFER_CARRY) begin : g_defer
      assign hold = cs_act && cmd_ok && !single_q && start_lo;
   end else begin : g_direct
      assign hold = 1'b0;
   end

   assign adv = !xstp_q && !hold && !tk_wr && (tick_1hz || pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ok   <= 1'b0;
         single_q <= 1'b0;
         rdm_q    <= 1'b0;
         used_q   <= 1'b0;
         start_lo <= 1'b0;
         addr_q   <= '0;
      end else if (!cs_act) begin
         cmd_ok <= 1'b0;
      end else if (rx_valid) begin
         if (rx_first) begin
            cmd_ok   <= 1'b1;
            addr_q   <= rx_byte[7:4];
            single_q <= (cmd_acc == ACC_SWR) || (cmd_acc == ACC_SRD);
            rdm_q    <= cmd_rd;
            used_q   <= 1'b0;
            start_lo <= (rx_byte[7:4] <= A_YEAR);
         end else if (cmd_ok) begin
            used_q <= 1'b1;
            if (!single_q) addr_q <= addr_q + 4'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h24_q  <= RESET_H24;
         xstp_q <= 1'b1;
         vlow_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_commit && addr_q == A_CTLA) h24_q <= rx_byte[5];
         if (ctlb_wr) xstp_q <= xstp_q & rx_byte[4];
         vlow_q <= vlow_in | (ctlb_wr ? (vlow_q & rx_byte[6]) : vlow_q);
         if (xstp_q)   pend_q <= 1'b0;
         else if (adv) pend_q <= tick_1hz & pend_q;
         else          pend_q <= pend_q | tick_1hz;
      end
   end

   rtc_timekeep #(.WDAY_LAST(WDAY_LAST), .RESET_H24(RESET_H24)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .h24     (h24_q),
      .wr_en   (tk_wr),
      .wr_addr (addr_q),
      .wr_data (rx_byte),
      .now     (now)
   );

   // R7
   osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xstp_q && !tk_wr) |=> $stable(now))
      else $error("time moved while oscillator stopped");

   // R13
   defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !tk_wr) |=> $stable(now))
      else $error("time moved during burst");

   // R12
   century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(now.cent) |-> ($past(tk_wr) || ($past(now.year) == 8'h99 && now.year == 8'h00)))
      else $error("century flag changed without year wrap");

endmodule

// File: tb/test_spi_bcd_rtc.sv
module test_spi_bcd_rtc;

   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, mosi = 1'b0, cs = 1'b0, tick = 1'b0, vlow = 1'b0;
   logic miso;
   int   errs = 0;
   int   checks = 0;
   logic [7:0] buf8 [8];

   always #4 clk = ~clk;

   spi_bcd_rtc i_spi_bcd_rtc (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (sck),
      .spi_mosi (mosi),
      .spi_miso (miso),
      .spi_cs   (cs),
      .tick_1hz (tick),
      .vlow_in  (vlow)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         repeat (HALF) @(negedge clk);
         sck = 1'b1; mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso; sck = 1'b0;
      end
   endtask

   task automatic sel();
      @(negedge clk); cs = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel();
      repeat (HALF) @(negedge clk); cs = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic wr1(input logic [3:0] a, input logic [7:0] d);
      logic [7:0] r;
      sel(); xbyte({a, 4'h8}, r); xbyte(d, r); desel();
   endtask

   task automatic rd1(input logic [3:0] a, output logic [7:0] d);
      logic [7:0] r;
      sel(); xbyte({a, 4'hC}, r); xbyte(8'h00, d); desel();
   endtask

   task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
      logic [7:0] r;
      sel();
      xbyte(8'h00, r); xbyte(s, r); xbyte(m, r); xbyte(h, r);
      xbyte(w, r); xbyte(d, r); xbyte(mo, r); xbyte(y, r);
      desel();
   endtask

   task automatic burst_rd(input logic [3:0] a, input int n);
      logic [7:0] r;
      sel(); xbyte({a, 4'h4}, r);
      for (int i = 0; i < n; i++) xbyte(8'h00, buf8[i]);
      desel();
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R2 miso idle", {7'b0, miso}, 8'h00);
      rd1(4'd0, v);  chk("R6 sec", v, 8'h00);
      rd1(4'd2, v);  chk("R6 hour", v, 8'h12);
      rd1(4'd3, v);  chk("R6 wday", v, 8'h00);
      rd1(4'd4, v);  chk("R6 day", v, 8'h01);
      rd1(4'd5, v);  chk("R6 month", v, 8'h01);
      rd1(4'd14, v); chk("R6 ctlA", v, 8'h00);
      rd1(4'd15, v); chk("R6 ctlB", v, 8'h10);
   endtask

   task automatic t_stopped();
      logic [7:0] v;
      pulse_tick();
      rd1(4'd0, v);  chk("R7 tick ignored while stopped", v, 8'h00);
      wr1(4'd15, 8'hFF);
      rd1(4'd15, v); chk("R7 write of ones keeps flag", v, 8'h10);
      wr1(4'd15, 8'h00);
      rd1(4'd15, v); chk("R7 flag cleared", v, 8'h00);
      pulse_tick();
      rd1(4'd0, v);  chk("R7 tick counts after clear", v, 8'h01);
   endtask

   task automatic t_vlow();
      logic [7:0] v;
      @(negedge clk); vlow = 1'b1;
      repeat (3) @(negedge clk); vlow = 1'b0;
      rd1(4'd15, v); chk("R8 low-voltage sticky", v, 8'h40);
      wr1(4'd15, 8'h00);
      rd1(4'd15, v); chk("R8 low-voltage cleared", v, 8'h00);
   endtask

   task automatic t_burst();
      set_time(8'h45, 8'h30, 8'h09, 8'h02, 8'h15, 8'h86, 8'h42);
      burst_rd(4'd0, 7);
      chk("R5 burst sec", buf8[0], 8'h45);
      chk("R5 burst min", buf8[1], 8'h30);
      chk("R5 burst hour", buf8[2], 8'h09);
      chk("R5 burst wday", buf8[3], 8'h02);
      chk("R5 burst day", buf8[4], 8'h15);
      chk("R3 month with century", buf8[5], 8'h86);
      chk("R5 burst year", buf8[6], 8'h42);
      burst_rd(4'd14, 4);
      chk("R5 wrap ctlA", buf8[0], 8'h00);
      chk("R5 wrap ctlB", buf8[1], 8'h00);
      chk("R5 wrap to sec", buf8[2], 8'h45);
      chk("R5 wrap to min", buf8[3], 8'h30);
   endtask

   task automatic t_single();
      logic [7:0] v, r;
      sel(); xbyte(8'h18, r); xbyte(8'h12, r); xbyte(8'h34, r); desel();
      rd1(4'd1, v); chk("R4 single write first byte only", v, 8'h12);
      rd1(4'd2, v); chk("R4 next address untouched", v, 8'h09);
      sel(); xbyte(8'h1C, r); xbyte(8'h00, v); xbyte(8'h00, r); desel();
      chk("R4 single read data", v, 8'h12);
      chk("R4 extra byte reads zero", r, 8'h00);
      sel(); xbyte(8'h1F, r); xbyte(8'h00, v); desel();
      chk("R1 low bits ignored", v, 8'h12);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr1(4'd0, 8'hD9); rd1(4'd0, v); chk("R3 sec bit7 reads 0", v, 8'h59);
      wr1(4'd3, 8'hFD); rd1(4'd3, v); chk("R3 wday field", v, 8'h05);
      wr1(4'd8, 8'h5A); rd1(4'd8, v); chk("R3 unused address", v, 8'h00);
   endtask

   task automatic t_roll24();
      wr1(4'd14, 8'h20);
      set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
      pulse_tick();
      burst_rd(4'd0, 7);
      chk("R9 sec", buf8[0], 8'h00);
      chk("R9 min", buf8[1], 8'h00);
      chk("R9 hour 23->00", buf8[2], 8'h00);
      chk("R11 wday wrap", buf8[3], 8'h00);
      chk("R11 day", buf8[4], 8'h01);
      chk("R12 century set", buf8[5], 8'h81);
      chk("R12 year wrap", buf8[6], 8'h00);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h92, 8'h99);
      pulse_tick();
      burst_rd(4'd5, 2);
      chk("R12 century cleared", buf8[0], 8'h01);
      chk("R12 year", buf8[1], 8'h00);
   endtask

   task automatic t_roll12();
      wr1(4'd14, 8'h00);
      set_time(8'h59, 8'h59, 8'h31, 8'h02, 8'h10, 8'h03, 8'h25);
      pulse_tick();
      burst_rd(4'd2, 3);
      chk("R10 11PM->12AM", buf8[0], 8'h12);
      chk("R10 day carry wday", buf8[1], 8'h03);
      chk("R10 day carry", buf8[2], 8'h11);
      set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h03, 8'h25);
      pulse_tick();
      burst_rd(4'd2, 3);
      chk("R10 11AM->12PM", buf8[0], 8'h32);
      chk("R10 no day carry", buf8[2], 8'h10);
      set_time(8'h59, 8'h59, 8'h32, 8'h02, 8'h10, 8'h03, 8'h25);
      pulse_tick();
      burst_rd(4'd2, 1);
      chk("R10 12PM->1PM", buf8[0], 8'h21);
   endtask

   task automatic cal_case(input string tag, input logic [7:0] d, mo, y,
                           input logic [7:0] ed, emo);
      set_time(8'h59, 8'h59, 8'h23, 8'h00, d, mo, y);
      pulse_tick();
      burst_rd(4'd4, 2);
      chk({"R11 day ", tag}, buf8[0], ed);
      chk({"R11 month ", tag}, buf8[1], emo);
   endtask

   task automatic t_cal();
      wr1(4'd14, 8'h20);
      cal_case("leap 28", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
      cal_case("leap 29", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
      cal_case("odd-tens leap", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
      cal_case("common 28", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
      cal_case("april", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
      cal_case("january", 8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
   endtask

   task automatic t_defer();
      logic [7:0] r, v;
      set_time(8'h59, 8'h10, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04);
      sel();
      xbyte(8'h04, r);
      repeat (10) @(negedge clk);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      for (int i = 0; i < 3; i++) xbyte(8'h00, buf8[i]);
      desel();
      chk("R13 sec held", buf8[0], 8'h59);
      chk("R13 min held", buf8[1], 8'h10);
      rd1(4'd0, v); chk("R13 pending sec applied", v, 8'h00);
      rd1(4'd1, v); chk("R13 pending min applied", v, 8'h11);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_stopped();
      t_vlow();
      t_burst();
      t_single();
      t_mask();
      t_roll24();
      t_roll12();
      t_cal();
      t_defer();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule